// File: doc/BRIEF.md
# Dual-Level PWM LED Channel Controller

This block turns a set of register values into eight LED drive waveforms. A fast free-running 8-bit counter gives every channel its own brightness PWM. A second, slower 8-bit counter produces one shared group signal. In dimming mode the group signal is a fixed-rate PWM that scales all channels together. In blink mode it becomes a slow on/off pattern whose period is programmable.

Each channel has a 2-bit state that selects its output. The output can be dark, lit without modulation, driven by its own PWM, or driven by its own PWM gated by the group signal. A shared stage then sets the output polarity and chooses open-drain or push-pull drive for all pins. An active-low enable acts without a clock edge and forces every pin to a selectable idle state. A sleep input stops both timers where they are.

Top module: `led_pwm_ctrl`

## Requirements
- R1: After reset both counters, both prescalers and every captured duty value are zero. A channel under PWM control therefore stays dark until its first period boundary.
- R2: The channel counter steps by one every IND_PRE clocks and wraps from 255 to 0. In state 2'b10 a channel is lit while the count is below its captured duty. Duty 0 never lights the channel. Duty 255 lights it for 255 of every 256 steps.
- R3: A channel's duty input is captured only on the step from 255 to 0. A change in the middle of a period does not alter the current period.
- R4: Channel state encoding: 2'b00 dark, 2'b01 lit with no modulation, 2'b10 own PWM only, 2'b11 own PWM AND group signal. Channel i uses bits [2i+1:2i] of `ch_mode`.
- R5: With `blink_sel`=0 the group counter steps every DIM_PRE clocks. The group signal is high while the group count is below the group duty. The group duty is captured when the group count wraps from 255 to 0.
- R6: With `blink_sel`=1 the group counter steps every (grp_freq+1)*BLINK_PRE clocks. Duty and capture work as in R5.
- R7: With `invert`=0 a lit channel drives its pin low and a dark one drives it high. With `invert`=1 both levels are swapped.
- R8: With `open_drain`=0 every `led_den` bit is 1 and `led_lvl` carries the pin level. With `open_drain`=1 every `led_lvl` bit is 0 and `led_den` is 1 only where the pin level is low.
- R9: While `oe_n`=1 every pin is forced at once, with no clock edge, according to `dis_sel`. 2'b00 drives the pin low. 2'b01 drives it high with push-pull drive and releases it with open-drain drive. 2'b1x releases it. A released pin has `led_den`=0 and `led_lvl`=0.
- R10: While `sleep`=1 both counters and both prescalers hold their values. When `sleep` falls they continue from those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_in | input | NCH*DW | Per-channel duty, channel i in bits [DW*i+DW-1:DW*i] |
| grp_duty | input | DW | Group duty / blink on fraction |
| grp_freq | input | DW | Blink period select |
| ch_mode | input | 2*NCH | Per-channel state fields |
| blink_sel | input | 1 | 0 group dimming, 1 group blinking |
| invert | input | 1 | Output polarity swap |
| open_drain | input | 1 | 1 open-drain, 0 push-pull for all pins |
| dis_sel | input | 2 | Pin state while disabled |
| sleep | input | 1 | Stops both timers |
| oe_n | input | 1 | Active-low output enable |
| led_lvl | output | NCH | Pin drive level |
| led_den | output | NCH | Pin drive enable |

## Verification
The bench aims first at the duty extremes. If 255 is mistaken for full on, the pin never goes dark for even one step. If 0 is mishandled, stray pulses appear. It changes a duty in the middle of a period, where a design that skips the capture register shows a shortened or doubled pulse. It switches between dimming and blink while the group counter is running, where a design with a wrong step limit drifts out of phase with the model. It raises the output enable between clock edges, where a design that registers the override responds one cycle late. It holds sleep across several periods, where a design whose prescaler keeps running resumes from the wrong count.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

    typedef enum logic [1:0] {
        CH_DARK = 2'b00,
        CH_LIT  = 2'b01,
        CH_OWN  = 2'b10,
        CH_MIX  = 2'b11
    } ch_mode_e;

    localparam logic [1:0] DIS_LOW  = 2'b00;
    localparam logic [1:0] DIS_HIGH = 2'b01;

endpackage

// File: rtl/led_ind_timer.sv
module led_ind_timer #(
    parameter int NCH     = 8,
    parameter int DW      = 8,
    parameter int IND_PRE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [NCH*DW-1:0] duty_in,
    output logic [DW-1:0]     cnt,
    output logic [NCH*DW-1:0] duty_lat
);
    localparam int PW = (IND_PRE > 1) ? $clog2(IND_PRE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(IND_PRE - 1);
    localparam logic [DW-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic [PW-1:0]     pre;
        logic [DW-1:0]     cnt;
        logic [NCH*DW-1:0] lat;
    } ind_st_t;

    ind_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (st_q.pre == PRE_LAST) begin
                st_d.pre = '0;
                st_d.cnt = st_q.cnt + DW'(1);
                if (st_q.cnt == CNT_LAST) begin
                    st_d.lat = duty_in;
                end
            end else begin
                st_d.pre = st_q.pre + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign duty_lat = st_q.lat;

endmodule

// File: rtl/led_grp_timer.sv
module led_grp_timer #(
    parameter int DW        = 8,
    parameter int DIM_PRE   = 512,
    parameter int BLINK_PRE = 4069
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          blink_sel,
    input  logic [DW-1:0] grp_freq,
    input  logic [DW-1:0] grp_duty,
    output logic [DW-1:0] gcnt,
    output logic          grp_on
);
    localparam int GPW = $clog2((2 ** DW) * BLINK_PRE + DIM_PRE + 1);
    localparam logic [GPW-1:0] DIM_LIM = GPW'(DIM_PRE);
    localparam logic [GPW-1:0] BLK_UNIT = GPW'(BLINK_PRE);
    localparam logic [DW-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic [GPW-1:0] pre;
        logic [DW-1:0]  cnt;
        logic [DW-1:0]  lat;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic [GPW-1:0] lim;

    always_comb begin
        if (blink_sel) begin
            lim = (GPW'(grp_freq) + GPW'(1)) * BLK_UNIT;
        end else begin
            lim = DIM_LIM;
        end
        st_d = st_q;
        if (run) begin
            if (st_q.pre >= lim - GPW'(1)) begin
                st_d.pre = '0;
                st_d.cnt = st_q.cnt + DW'(1);
                if (st_q.cnt == CNT_LAST) begin
                    st_d.lat = grp_duty;
                end
            end else begin
                st_d.pre = st_q.pre + GPW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gcnt   = st_q.cnt;
    assign grp_on = st_q.cnt < st_q.lat;

endmodule

// File: rtl/led_chan_out.sv
module led_chan_out
    import led_pwm_pkg::*;
(
    input  ch_mode_e   mode,
    input  logic       ind_on,
    input  logic       grp_on,
    input  logic       invert,
    input  logic       open_drain,
    input  logic       oe_n,
    input  logic [1:0] dis_sel,
    output logic       lvl,
    output logic       den
);
    logic lit;
    logic pin;

    always_comb begin
        unique case (mode)
            CH_DARK: lit = 1'b0;
            CH_LIT:  lit = 1'b1;
            CH_OWN:  lit = ind_on;
            default: lit = ind_on & grp_on;
        endcase
        pin = invert ? lit : ~lit;
        if (oe_n) begin
            if (dis_sel == DIS_LOW) begin
                lvl = 1'b0;
                den = 1'b1;
            end else if (dis_sel == DIS_HIGH) begin
                lvl = ~open_drain;
                den = ~open_drain;
            end else begin
                lvl = 1'b0;
                den = 1'b0;
            end
        end else if (open_drain) begin
            lvl = 1'b0;
            den = ~pin;
        end else begin
            lvl = pin;
            den = 1'b1;
        end
    end

endmodule

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl
    import led_pwm_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int DW        = 8,
    parameter int IND_PRE   = 1,
    parameter int DIM_PRE   = 512,
    parameter int BLINK_PRE = 4069
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*DW-1:0] duty_in,
    input  logic [DW-1:0]     grp_duty,
    input  logic [DW-1:0]     grp_freq,
    input  logic [2*NCH-1:0]  ch_mode,
    input  logic              blink_sel,
    input  logic              invert,
    input  logic              open_drain,
    input  logic [1:0]        dis_sel,
    input  logic              sleep,
    input  logic              oe_n,
    output logic [NCH-1:0]    led_lvl,
    output logic [NCH-1:0]    led_den
);
    logic [DW-1:0]     ind_cnt;
    logic [NCH*DW-1:0] duty_lat;
    logic [DW-1:0]     grp_cnt;
    logic              grp_on;
    logic              run;

    assign run = ~sleep;

    led_ind_timer #(.NCH(NCH), .DW(DW), .IND_PRE(IND_PRE)) u_ind (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .duty_in  (duty_in),
        .cnt      (ind_cnt),
        .duty_lat (duty_lat)
    );

    led_grp_timer #(.DW(DW), .DIM_PRE(DIM_PRE), .BLINK_PRE(BLINK_PRE)) u_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .blink_sel (blink_sel),
        .grp_freq  (grp_freq),
        .grp_duty  (grp_duty),
        .gcnt      (grp_cnt),
        .grp_on    (grp_on)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ind_on;
        assign ind_on = ind_cnt < duty_lat[DW*g +: DW];
        led_chan_out u_out (
            .mode       (ch_mode_e'(ch_mode[2*g +: 2])),
            .ind_on     (ind_on),
            .grp_on     (grp_on),
            .invert     (invert),
            .open_drain (open_drain),
            .oe_n       (oe_n),
            .dis_sel    (dis_sel),
            .lvl        (led_lvl[g]),
            .den        (led_den[g])
        );
    end

endmodule

// File: rtl/led_pwm_ctrl_chk.sv
module led_pwm_ctrl_chk #(
    parameter int NCH = 8,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              oe_n,
    input logic              open_drain,
    input logic              invert,
    input logic [1:0]        dis_sel,
    input logic [2*NCH-1:0]  ch_mode,
    input logic [NCH-1:0]    led_lvl,
    input logic [NCH-1:0]    led_den,
    input logic [DW-1:0]     ind_cnt,
    input logic [DW-1:0]     grp_cnt,
    input logic [NCH*DW-1:0] duty_lat
);
    localparam logic [DW-1:0] TOP = '1;

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ind_cnt) |-> ind_cnt == $past(ind_cnt) + DW'(1));

    assert_capture_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_lat) |-> $past(ind_cnt) == TOP);

    assert_pp_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_drain && !oe_n) |-> led_den == '1);

    assert_od_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (open_drain && !oe_n) |-> led_lvl == '0);

    assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && dis_sel == 2'b00) |-> (led_den == '1 && led_lvl == '0));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && dis_sel[1]) |-> (led_den == '0 && led_lvl == '0));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep) |-> ($stable(ind_cnt) && $stable(grp_cnt)));

    for (genvar g = 0; g < NCH; g++) begin : g_mode
        assert_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mode[2*g +: 2] == 2'b01 && !oe_n && !open_drain)
                |-> led_lvl[g] == invert);
        assert_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mode[2*g +: 2] == 2'b00 && !oe_n && !open_drain)
                |-> led_lvl[g] == !invert);
    end

endmodule

bind led_pwm_ctrl led_pwm_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .oe_n       (oe_n),
    .open_drain (open_drain),
    .invert     (invert),
    .dis_sel    (dis_sel),
    .ch_mode    (ch_mode),
    .led_lvl    (led_lvl),
    .led_den    (led_den),
    .ind_cnt    (ind_cnt),
    .grp_cnt    (grp_cnt),
    .duty_lat   (duty_lat)
);

// File: tb/led_pwm_ctrl_tb.sv
module led_pwm_ctrl_tb;
    localparam int NCH = 8;
    localparam int DW = 8;
    localparam int IND_PRE = 1;
    localparam int DIM_PRE = 3;
    localparam int BLINK_PRE = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*DW-1:0] duty_in = '0;
    logic [DW-1:0]     grp_duty = '0;
    logic [DW-1:0]     grp_freq = '0;
    logic [2*NCH-1:0]  ch_mode = '0;
    logic              blink_sel = 1'b0;
    logic              invert = 1'b0;
    logic              open_drain = 1'b0;
    logic [1:0]        dis_sel = 2'b00;
    logic              sleep = 1'b0;
    logic              oe_n = 1'b0;
    logic [NCH-1:0]    led_lvl;
    logic [NCH-1:0]    led_den;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    led_pwm_ctrl #(.NCH(NCH), .DW(DW), .IND_PRE(IND_PRE),
                   .DIM_PRE(DIM_PRE), .BLINK_PRE(BLINK_PRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .duty_in(duty_in), .grp_duty(grp_duty),
        .grp_freq(grp_freq), .ch_mode(ch_mode), .blink_sel(blink_sel),
        .invert(invert), .open_drain(open_drain), .dis_sel(dis_sel),
        .sleep(sleep), .oe_n(oe_n), .led_lvl(led_lvl), .led_den(led_den));

    // behavioural reference
    int m_pre, m_cnt, m_gpre, m_gcnt, m_gdut;
    int m_lat[NCH];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_gpre = 0; m_gcnt = 0; m_gdut = 0;
            for (int i = 0; i < NCH; i++) m_lat[i] = 0;
        end else if (!sleep) begin
            int lim;
            if (m_pre == IND_PRE - 1) begin
                m_pre = 0;
                if (m_cnt == 255) begin
                    m_cnt = 0;
                    for (int i = 0; i < NCH; i++) m_lat[i] = int'(duty_in[DW*i +: DW]);
                end else m_cnt++;
            end else m_pre++;
            lim = blink_sel ? (int'(grp_freq) + 1) * BLINK_PRE : DIM_PRE;
            if (m_gpre >= lim - 1) begin
                m_gpre = 0;
                if (m_gcnt == 255) begin
                    m_gcnt = 0;
                    m_gdut = int'(grp_duty);
                end else m_gcnt++;
            end else m_gpre++;
        end
    end

    function automatic void expect_pins(output logic [NCH-1:0] lv, output logic [NCH-1:0] de);
        for (int i = 0; i < NCH; i++) begin
            bit lit, pin;
            case (ch_mode[2*i +: 2])
                2'b00: lit = 0;
                2'b01: lit = 1;
                2'b10: lit = m_cnt < m_lat[i];
                default: lit = (m_cnt < m_lat[i]) && (m_gcnt < m_gdut);
            endcase
            pin = invert ? lit : !lit;
            if (oe_n) begin
                if (dis_sel == 2'b00) begin lv[i] = 0; de[i] = 1; end
                else if (dis_sel == 2'b01) begin lv[i] = !open_drain; de[i] = !open_drain; end
                else begin lv[i] = 0; de[i] = 0; end
            end else if (open_drain) begin
                lv[i] = 0; de[i] = !pin;
            end else begin
                lv[i] = pin; de[i] = 1;
            end
        end
    endfunction

    task automatic compare_now(string req);
        logic [NCH-1:0] lv, de;
        expect_pins(lv, de);
        n_cmp++;
        if (lv !== led_lvl || de !== led_den) begin
            n_bad++;
            $display("FAIL %s: lvl=%h den=%h expected lvl=%h den=%h", req, led_lvl, led_den, lv, de);
        end
    endtask

    task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) compare_now(cur_req);

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int on7, on0;
        logic [NCH-1:0] frozen;
        // R1: reset state, PWM channels dark until first wrap
        for (int i = 0; i < NCH; i++) duty_in[DW*i +: DW] = DW'(i * 36);
        duty_in[DW*7 +: DW] = 8'd255;
        ch_mode = {NCH{2'b10}};
        step(3);
        rst_n = 1'b1;
        step(10);
        check_val("R1", led_lvl, 8'hFF);
        step(200);
        // R2: duty extremes over two full periods
        cur_req = "R2";
        step(100);
        on7 = 0; on0 = 0;
        for (int k = 0; k < 512; k++) begin
            if (led_lvl[7] == 1'b0) on7++;
            if (led_lvl[0] == 1'b0) on0++;
            step(1);
        end
        check_val("R2", on7, 510);
        check_val("R2", on0, 0);
        // R3: mid-period change
        cur_req = "R3";
        step(100);
        duty_in[DW*3 +: DW] = 8'd20;
        step(600);
        // R4 / R5: mixed states with group dimming
        cur_req = "R4";
        ch_mode = 16'b11_10_01_00_11_10_01_00;
        grp_duty = 8'd128;
        step(1700);
        check_val("R4", led_lvl[1], 1'b0);
        cur_req = "R5";
        grp_duty = 8'd64;
        step(1700);
        // R6: blink mode, switched while running
        cur_req = "R6";
        blink_sel = 1'b1;
        grp_freq = 8'd3;
        grp_duty = 8'd128;
        step(4500);
        blink_sel = 1'b0;
        step(300);
        // R7: polarity
        cur_req = "R7";
        invert = 1'b1;
        step(600);
        check_val("R7", led_lvl[1], 1'b1);
        // R8: open-drain
        cur_req = "R8";
        open_drain = 1'b1;
        step(300);
        invert = 1'b0;
        step(300);
        check_val("R8", led_lvl, 8'h00);
        // R9: asynchronous disable, checked between edges
        cur_req = "R9";
        @(posedge clk); #3;
        dis_sel = 2'b01; oe_n = 1'b1; #1;
        check_val("R9", {led_lvl, led_den}, 16'h0000);
        open_drain = 1'b0; #1;
        check_val("R9", {led_lvl, led_den}, 16'hFFFF);
        dis_sel = 2'b00; #1;
        check_val("R9", {led_lvl, led_den}, 16'h00FF);
        dis_sel = 2'b10; #1;
        check_val("R9", {led_lvl, led_den}, 16'h0000);
        step(50);
        oe_n = 1'b0; dis_sel = 2'b00;
        step(100);
        // R10: sleep freezes timers
        cur_req = "R10";
        sleep = 1'b1;
        step(2);
        frozen = led_lvl;
        step(400);
        check_val("R10", led_lvl, frozen);
        sleep = 1'b0;
        step(900);
        finish_run();
    end

endmodule